// File: doc/BRIEF.md
# PS/2 Keyboard Indicator Update Sequencer

This block runs the host side of the exchange that sets the three lock indicators on a PS/2 keyboard. A one-cycle start pulse captures three request bits (caps, num, scroll). The block then hands the set-indicators command byte (0xED) to a byte transmitter and waits for the keyboard to acknowledge it with 0xFA. Only after that acknowledge does it send the indicator byte. By default it also waits for a second 0xFA before it reports completion.

The bit-level line signalling sits outside this block, in a transmitter with a send/busy handshake and a receiver that presents each received byte for one cycle with a valid strobe. Taking the clock line low before a transmission also belongs to that transmitter. The sequencer handles the rest of the exchange:

- a resend request (0xFE) from the keyboard causes the current byte to be transmitted again, with a bounded number of retries;
- a missing answer ends the exchange with an error pulse after a fixed number of cycles;
- any other received byte is ignored.

Top module: `kbd_led_seq`

## Requirements
- R1: After reset, tx_send_o, done_o and error_o are low and busy_o is low.
- R2: A start_i pulse while idle latches the three request bits and causes the command byte 0xED to be offered on tx_data_o with a one-cycle tx_send_o. tx_send_o is raised only in a cycle where tx_busy_i is low.
- R3: The indicator byte has caps in bit 2, num in bit 1 and scroll in bit 0, with bits 7 to 3 zero (a 1 lights the indicator). It is sent only after 0xFA has been received in answer to the command byte.
- R4: When 0xFA is received after the indicator byte, done_o pulses high for exactly one cycle and the block returns to idle.
- R5: When 0xFE is received while waiting for an answer, the byte just sent is transmitted again. Up to MAX_RESEND (3) resends are allowed per byte, and the next 0xFE after that ends the exchange with an error_o pulse.
- R6: If no 0xFA or 0xFE arrives, error_o rises on the edge ACK_WAIT_CYCLES clock cycles after the edge on which the wait began. It stays high for exactly one cycle.
- R7: A received byte other than 0xFA or 0xFE does not change the sequence. It causes no transmission and no error, and the exchange continues when 0xFA arrives.
- R8: start_i is ignored while an exchange is in progress. Changing the request bits after the start pulse does not alter the indicator byte.
- R9: busy_o is high from the edge after an accepted start until the block returns to idle. done_o and error_o are never high together.
- R10: While tx_busy_i is high, the block waits and does not raise tx_send_o. It sends as soon as tx_busy_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request an indicator update (one-cycle pulse) |
| caps_i | input | 1 | Caps indicator request |
| num_i | input | 1 | Num indicator request |
| scroll_i | input | 1 | Scroll indicator request |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| tx_send_o | output | 1 | One-cycle send strobe to the transmitter |
| tx_busy_i | input | 1 | Transmitter cannot accept a byte |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle failure pulse |

## Verification
The assertions check the following on every cycle:

- a send strobe never meets a busy transmitter;
- done and error are never high together, and each lasts exactly one cycle;
- the upper bits of the indicator byte are zero;
- the retry and timeout counters stay within their bounds.

Some behaviours can only be shown by the bench's directed scenarios:

- the order of command, acknowledge and indicator byte;
- the exact cycle at which the timeout fires;
- the count of allowed resends and the error on the next one;
- that stray bytes and late start pulses are ignored;
- that the request bits are latched at start.

// File: rtl/kbd_led_pkg.sv
package kbd_led_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND_CMD,
      ST_WAIT_CMD_ACK,
      ST_SEND_LED,
      ST_WAIT_LED_ACK,
      ST_DONE,
      ST_FAIL
   } seq_state_t;

   localparam logic [7:0] BYTE_SET_IND = 8'hED;
   localparam logic [7:0] BYTE_ACK     = 8'hFA;
   localparam logic [7:0] BYTE_RESEND  = 8'hFE;

   // Indicator byte: caps bit 2, num bit 1, scroll bit 0, rest zero.
   function automatic logic [7:0] pack_ind(input logic caps, input logic num, input logic scroll);
      return {5'b00000, caps, num, scroll};
   endfunction

endpackage

// File: rtl/kbd_led_timer.sv
module kbd_led_timer #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic expire_o
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("kbd_led_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || restart_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = run_i && (cnt_q == LAST);

   // R6: the wait counter never passes its limit
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R6: a restart always brings the counter back to zero
   a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/kbd_led_retry.sv
module kbd_led_retry #(
   parameter int MAX = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic bump_i,
   output logic exhausted_o
);
   localparam int RW = $clog2(MAX + 1) < 1 ? 1 : $clog2(MAX + 1);
   localparam logic [RW-1:0] TOP = RW'(MAX);

   generate
      if (MAX < 1) begin : g_bad_max
         $error("kbd_led_retry: MAX must be at least 1");
      end
   endgenerate

   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (bump_i && cnt_q != TOP) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign exhausted_o = (cnt_q == TOP);

   // R5: resend count stays within the allowed number
   a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP);

   // R5: no bump is requested once the budget is spent
   a_r5_no_bump_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted_o |-> !bump_i);

endmodule

// File: rtl/kbd_led_bytesel.sv
module kbd_led_bytesel
   import kbd_led_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       latch_i,
   input  logic       caps_i,
   input  logic       num_i,
   input  logic       scroll_i,
   input  logic       sel_ind_i,
   output logic [7:0] byte_o
);
   logic [2:0] req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
      end else if (latch_i) begin
         req_q <= {caps_i, num_i, scroll_i};
      end
   end

   assign byte_o = sel_ind_i ? pack_ind(req_q[2], req_q[1], req_q[0]) : BYTE_SET_IND;

   // R8: latched request bits change only on a latch strobe
   a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(latch_i) |-> $stable(req_q));

   // R3: upper bits of the indicator byte are zero
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ind_i |-> (byte_o[7:3] == 5'b00000));

endmodule

// File: rtl/kbd_led_seq.sv
module kbd_led_seq
   import kbd_led_pkg::*;
#(
   parameter int ACK_WAIT_CYCLES = 1000000,
   parameter int MAX_RESEND      = 3,
   parameter bit CHECK_LED_ACK   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       caps_i,
   input  logic       num_i,
   input  logic       scroll_i,
   output logic [7:0] tx_data_o,
   output logic       tx_send_o,
   input  logic       tx_busy_i,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_data_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       error_o
);
   seq_state_t state_q, state_d, after_ind;
   logic       bump, clear_retry, exhausted, expire;
   logic       in_send, in_wait, got_ack, got_resend;

   generate
      if (CHECK_LED_ACK) begin : g_led_ack
         assign after_ind = ST_WAIT_LED_ACK;
      end else begin : g_no_led_ack
         assign after_ind = ST_DONE;
      end
   endgenerate

   assign in_send    = (state_q == ST_SEND_CMD) || (state_q == ST_SEND_LED);
   assign in_wait    = (state_q == ST_WAIT_CMD_ACK) || (state_q == ST_WAIT_LED_ACK);
   assign got_ack    = rx_valid_i && (rx_data_i == BYTE_ACK);
   assign got_resend = rx_valid_i && (rx_data_i == BYTE_RESEND);

   always_comb begin
      state_d     = state_q;
      bump        = 1'b0;
      clear_retry = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d     = ST_SEND_CMD;
               clear_retry = 1'b1;
            end
         end
         ST_SEND_CMD: begin
            if (!tx_busy_i)  state_d = ST_WAIT_CMD_ACK;
            else if (expire) state_d = ST_FAIL;
         end
         ST_WAIT_CMD_ACK: begin
            if (got_ack) begin
               state_d     = ST_SEND_LED;
               clear_retry = 1'b1;
            end else if (got_resend) begin
               if (exhausted) begin
                  state_d = ST_FAIL;
               end else begin
                  state_d = ST_SEND_CMD;
                  bump    = 1'b1;
               end
            end else if (expire) begin
               state_d = ST_FAIL;
            end
         end
         ST_SEND_LED: begin
            if (!tx_busy_i)  state_d = after_ind;
            else if (expire) state_d = ST_FAIL;
         end
         ST_WAIT_LED_ACK: begin
            if (got_ack) begin
               state_d = ST_DONE;
            end else if (got_resend) begin
               if (exhausted) begin
                  state_d = ST_FAIL;
               end else begin
                  state_d = ST_SEND_LED;
                  bump    = 1'b1;
               end
            end else if (expire) begin
               state_d = ST_FAIL;
            end
         end
         ST_DONE: state_d = ST_IDLE;
         ST_FAIL: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   kbd_led_timer #(.LIMIT(ACK_WAIT_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (in_send || in_wait),
      .restart_i (state_d != state_q),
      .expire_o  (expire)
   );

   kbd_led_retry #(.MAX(MAX_RESEND)) u_retry (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear_retry),
      .bump_i      (bump),
      .exhausted_o (exhausted)
   );

   kbd_led_bytesel u_bytesel (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_i   ((state_q == ST_IDLE) && start_i),
      .caps_i    (caps_i),
      .num_i     (num_i),
      .scroll_i  (scroll_i),
      .sel_ind_i ((state_q == ST_SEND_LED) || (state_q == ST_WAIT_LED_ACK)),
      .byte_o    (tx_data_o)
   );

   assign tx_send_o = in_send && !tx_busy_i;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);
   assign error_o   = (state_q == ST_FAIL);

   // R10: never strobe a busy transmitter
   a_r10_no_send_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_send_o |-> !tx_busy_i);

   // R9: completion and failure are exclusive
   a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && error_o));

   // R4: done lasts one cycle
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: error lasts one cycle
   a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |=> !error_o);

   // R2: a send strobe is followed by a wait or done, never a second strobe
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      tx_send_o |=> !tx_send_o);

endmodule

// File: tb/kbd_led_seq_bench.sv
module kbd_led_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int T_WAIT     = 40;
   localparam int N_RESEND   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       caps_i = 1'b0, num_i = 1'b0, scroll_i = 1'b0;
   logic [7:0] tx_data_o;
   logic       tx_send_o;
   logic       tx_busy_i = 1'b0;
   logic       rx_valid_i = 1'b0;
   logic [7:0] rx_data_i = 8'h00;
   logic       busy_o, done_o, error_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kbd_led_seq #(.ACK_WAIT_CYCLES(T_WAIT), .MAX_RESEND(N_RESEND)) u_kbd_led_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .caps_i(caps_i), .num_i(num_i), .scroll_i(scroll_i),
      .tx_data_o(tx_data_o), .tx_send_o(tx_send_o), .tx_busy_i(tx_busy_i),
      .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
      .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start(input logic c, input logic n, input logic s);
      @(negedge clk);
      start_i = 1'b1; caps_i = c; num_i = n; scroll_i = s;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_send(output logic [7:0] b, output bit seen);
      seen = 1'b0;
      b = 8'h00;
      #1;
      for (int i = 0; i < 100; i++) begin
         if (tx_send_o) begin
            seen = 1'b1;
            b = tx_data_o;
            break;
         end
         @(negedge clk);
         #1;
      end
   endtask

   task automatic reply(input logic [7:0] b);
      @(posedge clk);
      @(negedge clk);
      rx_valid_i = 1'b1; rx_data_i = b;
      @(negedge clk);
      rx_valid_i = 1'b0; rx_data_i = 8'h00;
   endtask

   task automatic t_reset_state();
      do_reset();
      check(!tx_send_o && !done_o && !error_o && !busy_o, "R1",
            {tx_send_o, done_o, error_o, busy_o}, 0);
   endtask

   task automatic t_full(input logic c, input logic n, input logic s);
      logic [7:0] b; bit seen;
      pulse_start(c, n, s);
      check(busy_o, "R9", busy_o, 1);
      wait_send(b, seen);
      check(seen && b == 8'hED, "R2", b, 8'hED);
      reply(8'hFA);
      wait_send(b, seen);
      check(seen && b == {5'b0, c, n, s}, "R3", b, {5'b0, c, n, s});
      reply(8'hFA);
      check(done_o && !error_o, "R4", {done_o, error_o}, 2);
      @(negedge clk);
      check(!done_o && !busy_o, "R4", {done_o, busy_o}, 0);
   endtask

   task automatic t_resend_ok();
      logic [7:0] b; bit seen;
      pulse_start(1, 0, 1);
      wait_send(b, seen);
      for (int k = 0; k < N_RESEND; k++) begin
         reply(8'hFE);
         wait_send(b, seen);
         check(seen && b == 8'hED && !error_o, "R5", b, 8'hED);
      end
      reply(8'hFA);
      wait_send(b, seen);
      check(seen && b == 8'h05, "R5", b, 8'h05);
      reply(8'hFE);
      wait_send(b, seen);
      check(seen && b == 8'h05, "R5", b, 8'h05);
      reply(8'hFA);
      check(done_o, "R5", done_o, 1);
      @(negedge clk);
   endtask

   task automatic t_resend_exhaust();
      logic [7:0] b; bit seen;
      pulse_start(0, 1, 0);
      wait_send(b, seen);
      for (int k = 0; k < N_RESEND; k++) begin
         reply(8'hFE);
         wait_send(b, seen);
      end
      reply(8'hFE);
      check(error_o && !done_o, "R5", {error_o, done_o}, 2);
      @(negedge clk);
      check(!error_o && !busy_o, "R6", {error_o, busy_o}, 0);
   endtask

   task automatic t_timeout();
      logic [7:0] b; bit seen; int at;
      pulse_start(1, 1, 1);
      wait_send(b, seen);
      at = -1;
      for (int k = 1; k <= T_WAIT + 5; k++) begin
         @(negedge clk);
         if (error_o && at < 0) at = k;
      end
      check(at == T_WAIT + 1, "R6", at, T_WAIT + 1);
      check(!busy_o && !error_o, "R6", {busy_o, error_o}, 0);
   endtask

   task automatic t_ignore_other();
      logic [7:0] b; bit seen; bit bad;
      pulse_start(0, 0, 1);
      wait_send(b, seen);
      reply(8'hAA);
      bad = 1'b0;
      for (int k = 0; k < 4; k++) begin
         if (tx_send_o || error_o || !busy_o) bad = 1'b1;
         @(negedge clk);
      end
      check(!bad, "R7", bad, 0);
      reply(8'hFA);
      wait_send(b, seen);
      check(seen && b == 8'h01, "R7", b, 8'h01);
      reply(8'hFA);
      check(done_o, "R7", done_o, 1);
      @(negedge clk);
   endtask

   task automatic t_start_while_busy();
      logic [7:0] b; bit seen; int sends;
      pulse_start(1, 0, 0);
      caps_i = 0; num_i = 1; scroll_i = 1;
      wait_send(b, seen);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      sends = 0;
      for (int k = 0; k < 3; k++) begin
         if (tx_send_o) sends++;
         @(negedge clk);
      end
      check(sends == 0, "R8", sends, 0);
      reply(8'hFA);
      wait_send(b, seen);
      check(seen && b == 8'h04, "R8", b, 8'h04);
      reply(8'hFA);
      @(negedge clk);
      caps_i = 0; num_i = 0; scroll_i = 0;
   endtask

   task automatic t_tx_busy();
      logic [7:0] b; bit seen; bit bad;
      tx_busy_i = 1'b1;
      pulse_start(0, 1, 1);
      bad = 1'b0;
      for (int k = 0; k < 5; k++) begin
         if (tx_send_o) bad = 1'b1;
         @(negedge clk);
      end
      check(!bad, "R10", bad, 0);
      tx_busy_i = 1'b0;
      wait_send(b, seen);
      check(seen && b == 8'hED, "R10", b, 8'hED);
      reply(8'hFA);
      wait_send(b, seen);
      reply(8'hFA);
      check(done_o, "R10", done_o, 1);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      t_reset_state();
      t_full(1, 0, 0);
      t_full(0, 1, 0);
      t_full(0, 0, 1);
      t_full(1, 1, 1);
      t_full(0, 0, 0);
      t_resend_ok();
      t_resend_exhaust();
      t_timeout();
      t_ignore_other();
      t_start_while_busy();
      t_tx_busy();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule